// File: doc/BRIEF.md
# Carry-Select Binary Adder

This block adds two unsigned operands and a carry input in pure combinational logic and gives back a sum and a carry output. The operands are split into a low group and a high group, each of `GROUP_W` bits (4 by default, so the operands are 8 bits wide). The low group is a ripple chain of full-adder cells and is fed the external carry input.

The high group does not wait for the low group's carry. Two identical ripple groups compute the high result at the same time. One assumes an incoming carry of 0 and the other assumes 1. When the low group's carry out settles, a 2:1 selector takes the matching high sum and carry and drops the other.

The block has no clock and no reset. Its outputs follow its inputs. It is meant to sit in a datapath wherever a single-cycle add of this width is needed and a full eight-bit ripple would be too slow.

Top module: `csa_adder8`

## Requirements
- R1: For every combination of `a_in`, `b_in` and `carry_in`, the 9-bit value {`carry_out`, `sum_out`} equals `a_in + b_in + carry_in`.
- R2: The low `GROUP_W` bits of `sum_out` equal (low bits of `a_in` + low bits of `b_in` + `carry_in`) modulo 2^`GROUP_W`. The high operand bits have no effect on them.
- R3: When the low group produces no carry, the upper `GROUP_W` bits of `sum_out`, with `carry_out` above them, equal the sum of the upper operand bits alone.
- R4: When the low group produces a carry, the upper `GROUP_W` bits of `sum_out`, with `carry_out` above them, equal the sum of the upper operand bits plus one.
- R5: `carry_out` is 1 exactly when the total exceeds 2^(2*`GROUP_W`)-1. All-ones operands with `carry_in`=1 give `sum_out`=0xFF and `carry_out`=1.
- R6: A carry generated in the low group crosses into the high group. 0x0F + 0x00 + 1 gives `sum_out`=0x10 and `carry_out`=0.
- R7: The outputs depend only on the present inputs. They are valid in the same time step as an input change, without any clock edge.
- R8: All-zero inputs give `sum_out`=0x00 and `carry_out`=0.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 2*GROUP_W (8) | First unsigned operand |
| b_in | input | 2*GROUP_W (8) | Second unsigned operand |
| carry_in | input | 1 | Carry into the least significant bit |
| sum_out | output | 2*GROUP_W (8) | Sum, modulo 2^(2*GROUP_W) |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
Every result of this block is due zero clock cycles after its stimulus, because there is no register between the ports. The bench changes the inputs at a rising edge of its pacing clock and reads the outputs at the following falling edge, half a period later. Each comparison therefore sees settled values and is never taken at the moment of a change. For R7, the inputs are also changed with no edge at all and read back after a short delay in the same period.

// File: rtl/csa_pkg.sv
// Package: csa_pkg
// Shared constants for the carry-select adder. Holds the default group
// width and the number of groups; assumes exactly two groups.
package csa_pkg;
    localparam int unsigned CSA_GROUP_W_DEF = 4;
    localparam int unsigned CSA_NUM_GROUPS  = 2;
endpackage

// File: rtl/csa_full_add.sv
// Module: csa_full_add
// One-bit full adder in minimal two-level form: the sum is the four-minterm
// sum of products of odd parity, and the carry is the three-term majority.
// Assumes single-bit inputs; purely combinational.
module csa_full_add (
    input  logic x_bit,
    input  logic y_bit,
    input  logic c_bit,
    output logic s_bit,
    output logic co_bit
);
    // Two-level sum-of-products for sum and carry.
    always_comb begin
        s_bit  = (~x_bit & ~y_bit &  c_bit) |
                 (~x_bit &  y_bit & ~c_bit) |
                 ( x_bit & ~y_bit & ~c_bit) |
                 ( x_bit &  y_bit &  c_bit);
        co_bit = (x_bit & y_bit) | (x_bit & c_bit) | (y_bit & c_bit);
    end
endmodule

// File: rtl/csa_ripple_group.sv
// Module: csa_ripple_group
// WIDTH-bit ripple-carry adder. It chains WIDTH full-adder cells, each
// passing its carry to the next. Assumes WIDTH >= 1; combinational.
module csa_ripple_group #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_vec,
    input  logic [WIDTH-1:0] y_vec,
    input  logic             c_in,
    output logic [WIDTH-1:0] s_vec,
    output logic             c_out
);
    logic [WIDTH:0] chain;

    // Entry of the carry chain.
    assign chain[0] = c_in;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        csa_full_add u_fa (
            .x_bit  (x_vec[gi]),
            .y_bit  (y_vec[gi]),
            .c_bit  (chain[gi]),
            .s_bit  (s_vec[gi]),
            .co_bit (chain[gi+1])
        );
    end

    // Exit of the carry chain.
    assign c_out = chain[WIDTH];
endmodule

// File: rtl/csa_group_select.sv
// Module: csa_group_select
// 2:1 selector for a speculative group result (sum plus carry). It passes
// the carry-in-1 result when pick_one is set and otherwise the carry-in-0
// result. Assumes both inputs are already settled; combinational.
module csa_group_select #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] sum_if0,
    input  logic             cy_if0,
    input  logic [WIDTH-1:0] sum_if1,
    input  logic             cy_if1,
    input  logic             pick_one,
    output logic [WIDTH-1:0] sum_sel,
    output logic             cy_sel
);
    // Pick one of the two precomputed results.
    always_comb begin
        if (pick_one) begin
            sum_sel = sum_if1;
            cy_sel  = cy_if1;
        end else begin
            sum_sel = sum_if0;
            cy_sel  = cy_if0;
        end
    end
endmodule

// File: rtl/csa_adder8.sv
// Module: csa_adder8
// Two-group carry-select adder. The low group ripples from carry_in. The
// high group is computed twice at once, with carry-ins of 0 and 1, and the
// low group's carry picks between the two results. Assumes unsigned
// operands; no clock or reset.
module csa_adder8 #(
    parameter int unsigned GROUP_W = csa_pkg::CSA_GROUP_W_DEF
) (
    input  logic [csa_pkg::CSA_NUM_GROUPS*GROUP_W-1:0] a_in,
    input  logic [csa_pkg::CSA_NUM_GROUPS*GROUP_W-1:0] b_in,
    input  logic                                      carry_in,
    output logic [csa_pkg::CSA_NUM_GROUPS*GROUP_W-1:0] sum_out,
    output logic                                      carry_out
);
    localparam int unsigned DATA_W = csa_pkg::CSA_NUM_GROUPS * GROUP_W;

    logic [GROUP_W-1:0] lo_sum;
    logic               lo_carry;
    logic [GROUP_W-1:0] hi_sum0, hi_sum1, hi_sum_sel;
    logic               hi_cy0, hi_cy1;

    // Low group: ripples from the external carry.
    csa_ripple_group #(.WIDTH(GROUP_W)) u_lo (
        .x_vec (a_in[GROUP_W-1:0]),
        .y_vec (b_in[GROUP_W-1:0]),
        .c_in  (carry_in),
        .s_vec (lo_sum),
        .c_out (lo_carry)
    );

    // High group, assuming no incoming carry.
    csa_ripple_group #(.WIDTH(GROUP_W)) u_hi0 (
        .x_vec (a_in[DATA_W-1:GROUP_W]),
        .y_vec (b_in[DATA_W-1:GROUP_W]),
        .c_in  (1'b0),
        .s_vec (hi_sum0),
        .c_out (hi_cy0)
    );

    // High group, assuming an incoming carry.
    csa_ripple_group #(.WIDTH(GROUP_W)) u_hi1 (
        .x_vec (a_in[DATA_W-1:GROUP_W]),
        .y_vec (b_in[DATA_W-1:GROUP_W]),
        .c_in  (1'b1),
        .s_vec (hi_sum1),
        .c_out (hi_cy1)
    );

    // Low carry chooses the high result.
    csa_group_select #(.WIDTH(GROUP_W)) u_sel (
        .sum_if0  (hi_sum0),
        .cy_if0   (hi_cy0),
        .sum_if1  (hi_sum1),
        .cy_if1   (hi_cy1),
        .pick_one (lo_carry),
        .sum_sel  (hi_sum_sel),
        .cy_sel   (carry_out)
    );

    // Assemble the full sum.
    assign sum_out = {hi_sum_sel, lo_sum};
endmodule

// File: rtl/csa_adder8_chk.sv
// Module: csa_adder8_chk
// Assertion checker bound to csa_adder8. It compares the ports with
// behavioural arithmetic and checks the selection against the low carry.
// Immediate assertions only, since the block has no clock.
module csa_adder8_chk #(
    parameter int unsigned GROUP_W = 4
) (
    input logic [2*GROUP_W-1:0] a_in,
    input logic [2*GROUP_W-1:0] b_in,
    input logic                 carry_in,
    input logic [2*GROUP_W-1:0] sum_out,
    input logic                 carry_out,
    input logic                 lo_carry
);
    localparam int unsigned DATA_W = 2 * GROUP_W;

    logic [DATA_W:0]  full_ref;
    logic [GROUP_W:0] lo_ref;
    logic [GROUP_W:0] hi_plain;
    logic [GROUP_W:0] hi_got;

    // Behavioural reference values.
    always_comb begin
        full_ref = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, carry_in};
        lo_ref   = {1'b0, a_in[GROUP_W-1:0]} + {1'b0, b_in[GROUP_W-1:0]}
                 + {{GROUP_W{1'b0}}, carry_in};
        hi_plain = {1'b0, a_in[DATA_W-1:GROUP_W]} + {1'b0, b_in[DATA_W-1:GROUP_W]};
        hi_got   = {carry_out, sum_out[DATA_W-1:GROUP_W]};
    end

    // Checks of the port relations.
    always_comb begin
        p_total_r1: assert ({carry_out, sum_out} == full_ref)
            else $error("p_total_r1 violated");
        p_low_half_r2: assert (sum_out[GROUP_W-1:0] == lo_ref[GROUP_W-1:0])
            else $error("p_low_half_r2 violated");
        if (!lo_carry) begin
            p_pick_zero_r3: assert (hi_got == hi_plain)
                else $error("p_pick_zero_r3 violated");
        end else begin
            p_pick_one_r4: assert (hi_got == hi_plain + 1'b1)
                else $error("p_pick_one_r4 violated");
        end
        p_carry_out_r5: assert (carry_out == full_ref[DATA_W])
            else $error("p_carry_out_r5 violated");
    end
endmodule

bind csa_adder8 csa_adder8_chk #(.GROUP_W(GROUP_W)) u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .lo_carry  (lo_carry)
);

// File: tb/sim_csa_adder8.sv
module sim_csa_adder8;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned GW         = 4;
    localparam int unsigned DW         = 2 * GW;
    localparam int unsigned NVEC       = 12;
    localparam int unsigned WATCHDOG   = 200000;

    // Each vector: {a[7:0], b[7:0], cin, expected {cout,sum}[8:0]}
    localparam logic [25:0] VECS [NVEC] = '{
        {8'h00, 8'h00, 1'b0, 9'h000},
        {8'hFF, 8'hFF, 1'b1, 9'h1FF},
        {8'hFF, 8'h00, 1'b1, 9'h100},
        {8'h0F, 8'h00, 1'b1, 9'h010},
        {8'h0F, 8'h01, 1'b0, 9'h010},
        {8'hF0, 8'h10, 1'b0, 9'h100},
        {8'h80, 8'h80, 1'b0, 9'h100},
        {8'h55, 8'hAA, 1'b0, 9'h0FF},
        {8'h55, 8'hAA, 1'b1, 9'h100},
        {8'h7F, 8'h01, 1'b0, 9'h080},
        {8'h12, 8'h34, 1'b1, 9'h047},
        {8'hF8, 8'h07, 1'b0, 9'h0FF}
    };

    logic          clk;
    logic          rst_n;
    logic [DW-1:0] a_in, b_in, sum_out;
    logic          carry_in, carry_out;
    int            total;
    int            bad;
    bit            done;

    csa_adder8 #(.GROUP_W(GW)) u0 (
        .a_in      (a_in),
        .b_in      (b_in),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check9(input string req, input logic [8:0] got, input logic [8:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h cin=%b got=%h expected=%h", req, a_in, b_in, carry_in, got, exp);
        end
    endtask

    task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic c);
        @(posedge clk);
        a_in = a; b_in = b; carry_in = c;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        total = 0; bad = 0; done = 1'b0;
        rst_n = 1'b0;
        a_in = '0; b_in = '0; carry_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: zero inputs held during bench reset give zero outputs
        check9("R8", {carry_out, sum_out}, 9'h000);
        @(posedge clk);
        rst_n = 1'b1;

        // Table walk, R1 against stored expectations
        for (int i = 0; i < int'(NVEC); i++) begin
            drive(VECS[i][25:18], VECS[i][17:10], VECS[i][9]);
            check9("R1", {carry_out, sum_out}, VECS[i][8:0]);
        end

        // R3: low group gives no carry (3+4)
        drive(8'h93, 8'h24, 1'b0);
        check9("R3", {carry_out, sum_out}, 9'h0B7);
        // R4: low carry 9+8+1 lifts the high group 3+2 to 6
        drive(8'h39, 8'h28, 1'b1);
        check9("R4", {carry_out, sum_out}, 9'h062);
        // R4: low carry pushes 0xF high group into carry_out
        drive(8'hF8, 8'h08, 1'b0);
        check9("R4", {carry_out, sum_out}, 9'h100);
        // R2: low nibble 6+B+1 -> 2, for two different upper halves
        drive(8'hA6, 8'h5B, 1'b1);
        check9("R2", {5'b0, sum_out[3:0]}, 9'h002);
        drive(8'h36, 8'hEB, 1'b1);
        check9("R2", {5'b0, sum_out[3:0]}, 9'h002);
        // R5: all ones plus carry
        drive(8'hFF, 8'hFF, 1'b1);
        check9("R5", {carry_out, sum_out}, 9'h1FF);
        // R5: largest total without carry_out
        drive(8'hFE, 8'h01, 1'b0);
        check9("R5", {carry_out, sum_out}, 9'h0FF);
        // R6: carry crosses the group boundary
        drive(8'h0F, 8'h00, 1'b1);
        check9("R6", {carry_out, sum_out}, 9'h010);

        // R7: inputs change with no clock edge, outputs read 1 time unit later
        @(negedge clk);
        a_in = 8'h21; b_in = 8'h43; carry_in = 1'b0;
        #1;
        check9("R7", {carry_out, sum_out}, 9'h064);
        a_in = 8'hC0; b_in = 8'h50; carry_in = 1'b1;
        #1;
        check9("R7", {carry_out, sum_out}, 9'h111);

        // R1: every input combination against a behavioural sum
        for (int v = 0; v < (1 << 17); v++) begin
            logic [16:0] vb;
            vb = v[16:0];
            drive(vb[16:9], vb[8:1], vb[0]);
            check9("R1", {carry_out, sum_out},
                   {1'b0, vb[16:9]} + {1'b0, vb[8:1]} + {8'h00, vb[0]});
        end

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule